// File: doc/BRIEF.md
# Valley-skipping off-time regulator

This block is the digital core of a quasi-resonant switching controller. Once the transformer has demagnetized, it turns the power switch back on at a chosen zero crossing of the ringing waveform. A small saturating skip count sets which crossing that is. The switch turns off again when the current-sense comparator reports that the peak current has reached the feedback reference.

The skip count follows the load on a slow time scale. An internal prescaler divides the system clock down to one tick per regulation period (nominally 50 ms). Between ticks, two sticky flags record whether the feedback voltage was seen in the light-load band and whether it was seen in the heavy-load band. On each tick the count moves by at most one step and both flags clear. A feedback overload bypasses the tick and drops the count to its minimum at once, so full power is available straight away. The analog comparators, the gate driver and soft start sit outside this block.

Top module: `qr_offtime_ctrl`

## Requirements
- R1: After reset, gate_o is low, the skip count is 1, both range flags are clear, the prescaler is at zero and the controller waits for demagnetization.
- R2: With gate_o low, zero-crossing pulses before demag_i are ignored. After demag_i, gate_o rises one cycle after the zero-crossing pulse whose ordinal equals the skip count (1 = first crossing).
- R3: gate_o stays high until ilim_i is seen high, falls in the following cycle, and the controller then waits for demag_i again.
- R4: A tick occurs every TICK_DIV clock cycles, the first in cycle TICK_DIV after reset. Apart from overload, the skip count changes only on a tick.
- R5: If fb_low_i was high in any cycle of a period (and fb_high_i was not), the count rises by exactly one on the tick, however long the flag was held.
- R6: If neither fb_low_i nor fb_high_i was high during a period, the count holds on the tick.
- R7: If fb_high_i was high in any cycle of a period, the count falls by one on the tick, even when fb_low_i was also seen.
- R8: fb_over_i high sets the count to 1 in the next cycle, without waiting for a tick. It takes priority over a tick in the same cycle.
- R9: The count saturates at 15 going up and at 1 going down. It never wraps.
- R10: Both range flags clear on every tick. Inputs sampled in the tick cycle are dropped, so a flag seen in one period has no effect on the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_low_i | input | 1 | Feedback below light-load threshold |
| fb_high_i | input | 1 | Feedback above heavy-load threshold |
| fb_over_i | input | 1 | Feedback above overload threshold |
| demag_i | input | 1 | Transformer demagnetization complete |
| zc_i | input | 1 | One-cycle zero-crossing pulse |
| ilim_i | input | 1 | Current sense exceeds feedback reference |
| gate_o | output | 1 | Power switch gate enable |

## Verification
On every cycle, the bound checker confirms these properties:
- The skip count stays within 1 to 15.
- The count moves only on a tick or an overload, and never by more than one step.
- An overload leaves the count at 1.
- The range flags are empty after each tick.
- The gate only rises after a zero-crossing pulse and falls after the current limit.

The count itself is only visible through the gate. The bench therefore measures it by counting crossings in a probe cycle after each tick. Only those scenarios can show the following:
- once-per-period stepping;
- decrement priority;
- the flags being forgotten between periods;
- crossings being ignored before demagnetization.

// File: rtl/qr_offtime_ctrl.sv
module qr_offtime_ctrl #(
  parameter int TICK_DIV = 5000000,
  parameter int CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_low_i,
  input  logic fb_high_i,
  input  logic fb_over_i,
  input  logic demag_i,
  input  logic zc_i,
  input  logic ilim_i,
  output logic gate_o
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ST_WAIT, ST_COUNT, ST_ON} state_t;

  logic [PRE_W-1:0] pre;
  logic             tick;
  logic             flg_lo, flg_hi;
  logic [CNT_W-1:0] skip_cnt;
  logic [CNT_W-1:0] zc_cnt;
  logic [CNT_W-1:0] zc_nxt;
  state_t           state;

  assign tick   = (pre == PRE_LAST);
  assign zc_nxt = zc_cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tick) begin
      flg_lo <= 1'b0;
      flg_hi <= 1'b0;
    end else begin
      flg_lo <= flg_lo | fb_low_i;
      flg_hi <= flg_hi | fb_high_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fb_over_i) begin
      skip_cnt <= CNT_MIN;
    end else if (tick) begin
      if (flg_hi) begin
        if (skip_cnt != CNT_MIN) skip_cnt <= skip_cnt - CNT_W'(1);
      end else if (flg_lo) begin
        if (skip_cnt != CNT_MAX) skip_cnt <= skip_cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_WAIT;
      zc_cnt <= '0;
      gate_o <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: if (demag_i) begin
          state  <= ST_COUNT;
          zc_cnt <= '0;
        end
        ST_COUNT: if (zc_i) begin
          if (zc_nxt >= skip_cnt) begin
            state  <= ST_ON;
            gate_o <= 1'b1;
            zc_cnt <= '0;
          end else begin
            zc_cnt <= zc_nxt;
          end
        end
        ST_ON: if (ilim_i) begin
          state  <= ST_WAIT;
          gate_o <= 1'b0;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/qr_offtime_ctrl_chk.sv
module qr_offtime_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             flg_lo,
  input logic             flg_hi,
  input logic             fb_over_i,
  input logic             zc_i,
  input logic             ilim_i,
  input logic             gate_o
);
  a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CNT_W'(1)) && (cnt <= {CNT_W{1'b1}}));

  a_r8_overload_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
    fb_over_i |=> (cnt == CNT_W'(1)));

  a_r4_change_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !fb_over_i) |=> $stable(cnt));

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fb_over_i) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))
                              || (cnt == $past(cnt) - CNT_W'(1))));

  a_r10_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!flg_lo && !flg_hi));

  a_r3_off_on_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && ilim_i) |=> !gate_o);

  a_r2_rise_after_crossing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(zc_i));
endmodule

bind qr_offtime_ctrl qr_offtime_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(skip_cnt),
  .flg_lo(flg_lo), .flg_hi(flg_hi), .fb_over_i(fb_over_i),
  .zc_i(zc_i), .ilim_i(ilim_i), .gate_o(gate_o)
);

// File: tb/qr_offtime_ctrl_bench.sv
`timescale 1ns/1ps
module qr_offtime_ctrl_bench;
  localparam int DIV = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_low_i = 0, fb_high_i = 0, fb_over_i = 0, demag_i = 0, zc_i = 0, ilim_i = 0;
  logic gate_o;

  int errors = 0;
  int checks = 0;
  int m_pre = 0;
  int m_cnt = 1;
  bit m_lo = 0, m_hi = 0, last_tick = 0;

  always #2 clk = ~clk;

  qr_offtime_ctrl #(.TICK_DIV(DIV), .CNT_W(4)) u_qr_offtime_ctrl (
    .clk(clk), .rst_n(rst_n), .fb_low_i(fb_low_i), .fb_high_i(fb_high_i),
    .fb_over_i(fb_over_i), .demag_i(demag_i), .zc_i(zc_i), .ilim_i(ilim_i),
    .gate_o(gate_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected skip count after one clock, computed from R4..R10.
  task automatic step(input bit lo, input bit hi, input bit ov,
                      input bit dm, input bit zc, input bit il);
    fb_low_i = lo; fb_high_i = hi; fb_over_i = ov;
    demag_i = dm; zc_i = zc; ilim_i = il;
    @(posedge clk);
    last_tick = (m_pre == DIV - 1);
    if (ov) m_cnt = 1;
    else if (last_tick) begin
      if (m_hi) m_cnt = (m_cnt > 1) ? m_cnt - 1 : 1;
      else if (m_lo) m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
    end
    if (last_tick) begin m_lo = 0; m_hi = 0; end
    else begin m_lo = m_lo | lo; m_hi = m_hi | hi; end
    m_pre = last_tick ? 0 : m_pre + 1;
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic wait_tick();
    do idle(); while (!last_tick);
  endtask

  // Measures the skip count through the gate: demag, then count crossings.
  task automatic probe(input string tag);
    int got = 0;
    step(0, 0, 0, 1, 0, 0);
    for (int i = 1; i <= 16; i++) begin
      step(0, 0, 0, 0, 1, 0);
      if (gate_o) begin got = i; break; end
      idle();
    end
    chk(got, m_cnt, tag);
    idle(); idle();
    chk(gate_o, 1, "R3 gate holds until limit");
    step(0, 0, 0, 0, 0, 1);
    chk(gate_o, 0, "R3 gate off after limit");
  endtask

  task automatic period(input int plo, input int phi, input string tag);
    do step(($urandom % 100) < plo, ($urandom % 100) < phi, 0, 0, 0, 0);
    while (!last_tick);
    probe(tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk(gate_o, 0, "R1 gate low in reset");
    rst_n = 1'b1;
    chk(gate_o, 0, "R1 gate low after reset");
    probe("R1 R2 reset count is 1");

    wait_tick();
    repeat (3) step(0, 0, 0, 0, 1, 0);
    chk(gate_o, 0, "R2 crossings before demag ignored");
    probe("R2 skip count after ignored crossings");

    step(1, 0, 0, 0, 0, 0);
    probe("R4 no change before tick");
    wait_tick();
    probe("R5 step up on tick");

    period(100, 0, "R5 held low flag steps once");
    period(0, 0, "R6 hold without flags");
    for (int k = 0; k < 14; k++) period(30, 0, "R5 count up");
    chk(m_cnt, 15, "R9 model reached top");
    period(100, 0, "R9 saturate at 15");

    period(50, 50, "R7 high wins over low");
    period(0, 0, "R10 flags cleared after tick");

    step(0, 0, 1, 0, 0, 0);
    probe("R8 overload sets 1 at once");
    period(0, 100, "R9 saturate at 1");
    period(100, 0, "R5 up from 1");
    period(100, 0, "R5 up again");
    wait_tick();
    step(0, 0, 1, 0, 0, 0);
    probe("R8 overload again");

    for (int k = 0; k < 20; k++)
      period($urandom % 60, $urandom % 20, "R5 R6 R7 random period");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R4 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule